// File: doc/BRIEF.md
# Serial channel status and error flags

This block holds the status word of one channel of a multi-mode serial unit. It keeps two updating flags. The communication-active flag is high while the shift engine runs a transfer. The buffer-full flag is high while the single data buffer holds data that nobody has consumed yet. The block also holds three sticky error flags: framing, parity and overrun.

The bus side supplies strobes for writes to and reads from the data buffer, the channel's transmit and receive enable bits, and the channel's start and stop command strobes. The serial engine supplies one-cycle pulses: transfer begin, transfer done, buffer moved into the shift register, received data stored, framing error and parity error. Each error flag has its own clear pulse. The status word comes from registered flags and can be read as a 16-bit word or as its low byte. Bus writes to the status address are ignored.

All flags update on the clock edge that samples their events. An event on the inputs therefore shows in `stat_word` one cycle later.

Top module: `ser_stat_flags`

## Requirements
- R1: After reset `stat_word` is 16'h0000. Bits 15..7, 4 and 3 always read 0. The flags sit at bit 6 (active), bit 5 (buffer full), bit 2 (framing), bit 1 (parity) and bit 0 (overrun).
- R2: A `xfer_begin` pulse sets bit 6. A `xfer_done` pulse clears bit 6.
- R3: A `cmd_start` or `cmd_stop` pulse clears bit 6 and bit 5. It leaves bits 2..0 unchanged.
- R4: `buf_wr` with `tx_en`=1 sets bit 5. `buf_wr` with `tx_en`=0 does not set it. A `shift_load` pulse clears bit 5.
- R5: `rx_store` with `rx_en`=1 sets bit 5. `rx_store` with `rx_en`=0 does not set it. A `buf_rd` pulse clears bit 5.
- R6: A `frame_err` pulse sets bit 2 and bit 5. A `parity_err` pulse sets bit 1 and bit 5.
- R7: A `buf_wr` or `rx_store` pulse that arrives while bit 5 is 1 sets bit 0 (overrun). Overrun does not otherwise change bit 5.
- R8: When a set event and a clear event for the same flag arrive in the same cycle, the flag ends up 1.
- R9: Each error flag stays at 1 until its own clear pulse (`clr_frame`, `clr_parity`, `clr_ovr`) arrives or reset is asserted.
- R10: `stat_wr` with any `stat_wdata` changes no bit of `stat_word`.
- R11: `stat_byte` always equals `stat_word[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable bit of the channel |
| rx_en | input | 1 | Receive enable bit of the channel |
| buf_wr | input | 1 | Bus write strobe to the data buffer |
| buf_rd | input | 1 | Bus read strobe from the data buffer |
| shift_load | input | 1 | Engine moved the buffer into the shift register |
| rx_store | input | 1 | Engine stored received data into the buffer |
| xfer_begin | input | 1 | Engine started a transfer |
| xfer_done | input | 1 | Engine completed the communication operation |
| frame_err | input | 1 | Framing error detected |
| parity_err | input | 1 | Parity error detected |
| cmd_start | input | 1 | Start command bit written with 1 |
| cmd_stop | input | 1 | Stop command bit written with 1 |
| clr_frame | input | 1 | Clear pulse for the framing flag |
| clr_parity | input | 1 | Clear pulse for the parity flag |
| clr_ovr | input | 1 | Clear pulse for the overrun flag |
| stat_wr | input | 1 | Bus write strobe to the status address (ignored) |
| stat_wdata | input | 16 | Bus write data to the status address (ignored) |
| stat_word | output | 16 | Status word |
| stat_byte | output | 8 | Low byte of the status word |

## Verification
The hardest cases are those where one flag sees a set and a clear in the same cycle. One is a data write that meets a read or shift-load while the buffer is already full: this raises overrun and must still leave buffer-full at 1. Another is a start command that arrives with a reception error: buffer-full must stay set while the error flag is kept. Directed sequences first fill the buffer and then fire the colliding strobes together. Random cycles, driven with a high enable rate and sparse pulses, cover the other combinations, and a bench model predicts each cycle.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  localparam int STAT_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int NFLAG   = 5;
  localparam int ACT_BIT = 6;
  localparam int BFF_BIT = 5;
  localparam int FRM_BIT = 2;
  localparam int PAR_BIT = 1;
  localparam int OVR_BIT = 0;

  // index of each flag inside the flag vector
  localparam int IX_OVR = 0;
  localparam int IX_PAR = 1;
  localparam int IX_FRM = 2;
  localparam int IX_BFF = 3;
  localparam int IX_ACT = 4;

  typedef struct packed {
    logic [NFLAG-1:0] set;
    logic [NFLAG-1:0] clr;
  } ssf_evt_t;

  function automatic logic flag_next(input logic q, input logic s, input logic c);
    return s | (q & ~c);
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic [NFLAG-1:0] f);
    logic [STAT_W-1:0] w;
    w = '0;
    w[ACT_BIT] = f[IX_ACT];
    w[BFF_BIT] = f[IX_BFF];
    w[FRM_BIT] = f[IX_FRM];
    w[PAR_BIT] = f[IX_PAR];
    w[OVR_BIT] = f[IX_OVR];
    return w;
  endfunction

  function automatic logic [STAT_W-1:0] used_mask();
    return pack_status({NFLAG{1'b1}});
  endfunction
endpackage

// File: rtl/ssf_event_dec.sv
module ssf_event_dec
  import ssf_pkg::*;
(
  input  logic     tx_en,
  input  logic     rx_en,
  input  logic     buf_wr,
  input  logic     buf_rd,
  input  logic     shift_load,
  input  logic     rx_store,
  input  logic     xfer_begin,
  input  logic     xfer_done,
  input  logic     frame_err,
  input  logic     parity_err,
  input  logic     cmd_start,
  input  logic     cmd_stop,
  input  logic     clr_frame,
  input  logic     clr_parity,
  input  logic     clr_ovr,
  input  logic     full_q,
  output ssf_evt_t evt,
  output logic     overrun_evt,
  output logic     rx_err_evt,
  output logic     cmd_evt,
  output logic     fill_evt
);
  always_comb begin
    overrun_evt = (buf_wr | rx_store) & full_q;
    rx_err_evt  = frame_err | parity_err;
    cmd_evt     = cmd_start | cmd_stop;
    fill_evt    = (buf_wr & tx_en) | (rx_store & rx_en);

    evt = '0;
    evt.set[IX_ACT] = xfer_begin;
    evt.clr[IX_ACT] = xfer_done | cmd_evt;
    evt.set[IX_BFF] = fill_evt | rx_err_evt;
    evt.clr[IX_BFF] = shift_load | buf_rd | cmd_evt;
    evt.set[IX_FRM] = frame_err;
    evt.clr[IX_FRM] = clr_frame;
    evt.set[IX_PAR] = parity_err;
    evt.clr[IX_PAR] = clr_parity;
    evt.set[IX_OVR] = overrun_evt;
    evt.clr[IX_OVR] = clr_ovr;
  end
endmodule

// File: rtl/ssf_flag.sv
module ssf_flag
  import ssf_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= flag_next(q, set_i, clr_i);
  end
endmodule

// File: rtl/ssf_pack.sv
module ssf_pack
  import ssf_pkg::*;
(
  input  logic [NFLAG-1:0]  flags,
  output logic [STAT_W-1:0] word_o,
  output logic [BYTE_W-1:0] byte_o
);
  always_comb begin
    word_o = pack_status(flags);
    byte_o = word_o[BYTE_W-1:0];
  end
endmodule

// File: rtl/ser_stat_flags.sv
module ser_stat_flags
  import ssf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              buf_wr,
  input  logic              buf_rd,
  input  logic              shift_load,
  input  logic              rx_store,
  input  logic              xfer_begin,
  input  logic              xfer_done,
  input  logic              frame_err,
  input  logic              parity_err,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              clr_frame,
  input  logic              clr_parity,
  input  logic              clr_ovr,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic [STAT_W-1:0] stat_word,
  output logic [BYTE_W-1:0] stat_byte
);
  ssf_evt_t         evt;
  logic [NFLAG-1:0] flag_q;
  logic             overrun_evt;
  logic             rx_err_evt;
  logic             cmd_evt;
  logic             fill_evt;
  logic             unused_stat_wr;

  // the status address is read-only: its write port is sunk here
  assign unused_stat_wr = stat_wr ^ (^stat_wdata);

  ssf_event_dec u_dec (
    .tx_en, .rx_en, .buf_wr, .buf_rd, .shift_load, .rx_store,
    .xfer_begin, .xfer_done, .frame_err, .parity_err,
    .cmd_start, .cmd_stop, .clr_frame, .clr_parity, .clr_ovr,
    .full_q      (flag_q[IX_BFF]),
    .evt         (evt),
    .overrun_evt (overrun_evt),
    .rx_err_evt  (rx_err_evt),
    .cmd_evt     (cmd_evt),
    .fill_evt    (fill_evt)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    ssf_flag #(.RST_VAL(1'b0)) u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt.set[i]),
      .clr_i (evt.clr[i]),
      .q     (flag_q[i])
    );
  end

  ssf_pack u_pack (
    .flags  (flag_q),
    .word_o (stat_word),
    .byte_o (stat_byte)
  );
endmodule

// File: rtl/ssf_chk.sv
module ssf_chk
  import ssf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_begin,
  input logic              xfer_done,
  input logic              clr_frame,
  input logic              clr_parity,
  input logic              clr_ovr,
  input logic              frame_err,
  input logic              parity_err,
  input logic              overrun_evt,
  input logic              cmd_evt,
  input logic              fill_evt,
  input logic              rx_err_evt,
  input logic [STAT_W-1:0] stat_word,
  input logic [BYTE_W-1:0] stat_byte
);
  // R1
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word & ~used_mask()) == '0);
  // R2
  act_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_begin |=> stat_word[ACT_BIT]);
  // R2
  act_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !xfer_begin |=> !stat_word[ACT_BIT]);
  // R3
  cmd_clr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_evt && !fill_evt && !rx_err_evt |=> !stat_word[BFF_BIT]);
  // R6
  rx_err_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_evt |=> stat_word[BFF_BIT]);
  // R7
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> stat_word[OVR_BIT]);
  // R9
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[FRM_BIT] && !clr_frame |=> stat_word[FRM_BIT]);
  // R9
  parity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[PAR_BIT] && !clr_parity |=> stat_word[PAR_BIT]);
  // R9
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[OVR_BIT] && !clr_ovr |=> stat_word[OVR_BIT]);
  // R8
  frame_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err && clr_frame |=> stat_word[FRM_BIT]);
  // R8
  parity_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err && clr_parity |=> stat_word[PAR_BIT]);
  // R11
  low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte == stat_word[BYTE_W-1:0]);
endmodule

bind ser_stat_flags ssf_chk u_chk (
  .clk, .rst_n, .xfer_begin, .xfer_done, .clr_frame, .clr_parity, .clr_ovr,
  .frame_err, .parity_err, .overrun_evt, .cmd_evt, .fill_evt, .rx_err_evt,
  .stat_word, .stat_byte
);

// File: tb/ser_stat_flags_tb.sv
module ser_stat_flags_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en, rx_en, buf_wr, buf_rd, shift_load, rx_store, xfer_begin, xfer_done;
  logic frame_err, parity_err, cmd_start, cmd_stop, clr_frame, clr_parity, clr_ovr, stat_wr;
  logic [15:0] stat_wdata;
  logic [15:0] stat_word;
  logic [7:0]  stat_byte;

  int n_chk = 0;
  int n_fail = 0;
  // model flags: active, full, frame, parity, overrun
  logic m_act, m_full, m_frm, m_par, m_ovr;

  always #2 clk = ~clk;

  ser_stat_flags u_dut (
    .clk, .rst_n, .tx_en, .rx_en, .buf_wr, .buf_rd, .shift_load, .rx_store,
    .xfer_begin, .xfer_done, .frame_err, .parity_err, .cmd_start, .cmd_stop,
    .clr_frame, .clr_parity, .clr_ovr, .stat_wr, .stat_wdata, .stat_word, .stat_byte
  );

  function automatic logic [15:0] exp_word();
    return {9'd0, m_act, m_full, 2'b00, m_frm, m_par, m_ovr};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    {buf_wr, buf_rd, shift_load, rx_store, xfer_begin, xfer_done} = '0;
    {frame_err, parity_err, cmd_start, cmd_stop, clr_frame, clr_parity, clr_ovr, stat_wr} = '0;
    stat_wdata = '0;
  endtask

  // advance the model from the inputs now applied (called before the edge)
  task automatic model_step();
    logic s, c, ov;
    ov = (buf_wr | rx_store) & m_full;
    s = xfer_begin; c = xfer_done | cmd_start | cmd_stop;
    m_act = s ? 1'b1 : (c ? 1'b0 : m_act);
    s = (buf_wr & tx_en) | (rx_store & rx_en) | frame_err | parity_err;
    c = shift_load | buf_rd | cmd_start | cmd_stop;
    m_full = s ? 1'b1 : (c ? 1'b0 : m_full);
    m_frm = frame_err  ? 1'b1 : (clr_frame  ? 1'b0 : m_frm);
    m_par = parity_err ? 1'b1 : (clr_parity ? 1'b0 : m_par);
    m_ovr = ov         ? 1'b1 : (clr_ovr    ? 1'b0 : m_ovr);
  endtask

  // inputs are applied at a negedge; one edge later the result is checked
  task automatic cycle(input string tag);
    model_step();
    @(negedge clk);
    check(tag, stat_word, exp_word());
    check("R11", {8'd0, stat_byte}, {8'd0, stat_word[7:0]});
    idle();
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    tx_en = 1'b1; rx_en = 1'b1;
    {m_act, m_full, m_frm, m_par, m_ovr} = '0;
    #9;
    check("R1 reset", stat_word, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R2 active set then done
    xfer_begin = 1'b1; cycle("R2 begin");
    xfer_done = 1'b1;  cycle("R2 done");
    // R4 write fills, shift_load empties; disabled tx does not fill
    buf_wr = 1'b1; cycle("R4 write fills");
    shift_load = 1'b1; cycle("R4 shift empties");
    tx_en = 1'b0; buf_wr = 1'b1; cycle("R4 write with tx off");
    tx_en = 1'b1;
    // R5 receive store and bus read
    rx_store = 1'b1; cycle("R5 store fills");
    buf_rd = 1'b1; cycle("R5 read empties");
    rx_en = 1'b0; rx_store = 1'b1; cycle("R5 store with rx off");
    rx_en = 1'b1;
    // R7 overrun: write while full, combined with a read (R8 set wins)
    buf_wr = 1'b1; cycle("R7 fill");
    buf_wr = 1'b1; buf_rd = 1'b1; cycle("R8 write+read while full");
    // R6 errors set buffer full
    shift_load = 1'b1; cycle("R4 empty again");
    frame_err = 1'b1; cycle("R6 frame");
    buf_rd = 1'b1; cycle("R5 empty");
    parity_err = 1'b1; cycle("R6 parity");
    // R3 commands clear updating flags only, R8 error beats cmd on full
    xfer_begin = 1'b1; cycle("R2 begin");
    cmd_stop = 1'b1; cycle("R3 stop");
    xfer_begin = 1'b1; buf_wr = 1'b1; cycle("R3 refill");
    cmd_start = 1'b1; cycle("R3 start");
    cmd_start = 1'b1; frame_err = 1'b1; cycle("R8 error with start");
    // R10 status write ignored
    stat_wr = 1'b1; stat_wdata = 16'hFFFF; cycle("R10 write ones");
    stat_wr = 1'b1; stat_wdata = 16'h0000; cycle("R10 write zeros");
    // R9 each error clears only with its own pulse
    clr_parity = 1'b1; cycle("R9 clear parity");
    clr_frame = 1'b1; clr_ovr = 1'b1; cycle("R9 clear frame+ovr");
    parity_err = 1'b1; clr_parity = 1'b1; cycle("R8 parity set wins");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      tx_en      = ($urandom % 4) != 0;
      rx_en      = ($urandom % 4) != 0;
      buf_wr     = ($urandom % 5) == 0;
      buf_rd     = ($urandom % 6) == 0;
      shift_load = ($urandom % 6) == 0;
      rx_store   = ($urandom % 6) == 0;
      xfer_begin = ($urandom % 6) == 0;
      xfer_done  = ($urandom % 6) == 0;
      frame_err  = ($urandom % 16) == 0;
      parity_err = ($urandom % 16) == 0;
      cmd_start  = ($urandom % 20) == 0;
      cmd_stop   = ($urandom % 20) == 0;
      clr_frame  = ($urandom % 10) == 0;
      clr_parity = ($urandom % 10) == 0;
      clr_ovr    = ($urandom % 10) == 0;
      stat_wr    = ($urandom % 8) == 0;
      stat_wdata = 16'($urandom);
      cycle("R1 R2 R4 R5 R7 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule